// File: doc/BRIEF.md
# Clustered Voltage/Frequency Reconfiguration Controller

This controller manages a rectangular grid of network regions. Each region reports its buffer occupancy on every cycle. The controller sums those values over a fixed window and, at the end of the window, gives each region one of two operating points: low or high.

Adjacent regions that end up on the same operating point form one cluster. A link between two regions on different operating points is a cluster boundary, and it must run through a synchronising FIFO. A link inside a cluster uses a plain wire path.

When the new assignment differs from the current one, the controller runs a fixed sequence:

1. It puts every link that is a boundary in either the old or the new assignment into FIFO mode.
2. It waits until each link that has just switched to FIFO mode confirms the change.
3. It issues the new per-region level requests.
4. It waits until each region whose level changed confirms that its supply and clock are stable.
5. It commits the new assignment. Only at this point do links that are now inside a cluster return to wire mode.

A window result that arrives while a sequence is running is held and applied once the controller is idle again.

The control pins are plain levels and pulses. No streaming data passes through the block, so there is no valid/ready back-pressure. An acknowledge pulse is taken on the cycle it appears. Pulses on bits the controller is not waiting for are ignored.

Top module: `dvfs_cluster_ctrl`

## Requirements
- R1: A window counter starts at zero on reset and counts WINDOW cycles (default 50), then wraps. Each decision uses the occupancy sampled on every cycle of the window, including its last cycle.
- R2: Region index is row*COLS+col, and its occupancy sits at bits [index*OCC_W +: OCC_W]. A region's decided level is high (1) only when its window sum is strictly greater than thresh_i*WINDOW. A sum equal to that limit gives low (0). thresh_i is sampled on the last cycle of the window.
- R3: Level requests change only on the clock edge that ends the interface phase. The interface phase begins on the edge that ends the deciding window.
- R4: Link indices are as follows. A horizontal link between (r,c) and (r,c+1) has index r*(COLS-1)+c. A vertical link between (r,c) and (r+1,c) has index ROWS*(COLS-1)+r*COLS+c. Mode 1 is FIFO and 0 is wire. While idle, a link's mode is the XOR of the requested levels at its two ends. During a sequence, a link is in FIFO mode if it is a boundary under the old levels or under the new levels.
- R5: The interface phase ends on the edge where every link newly placed in FIFO mode has had its link_done_i pulse. If no link changed mode, the phase lasts exactly one cycle.
- R6: The supply phase ends on the edge where every region whose level changes has had its lvl_done_i pulse. On that edge, the link modes take the XOR map of the new levels. No link leaves FIFO mode at any other time.
- R7: A window that ends during a sequence stores its decision, and a later window overwrites an earlier stored one. The stored decision is applied on the first idle cycle, unless a window also ends in that cycle; in that case the fresh decision wins.
- R8: A decision equal to the current levels changes no output and starts no sequence.
- R9: After reset, all level requests are low and all links are in wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_i | input | NREG*OCC_W (64) | Per-region buffer occupancy, sampled every cycle |
| thresh_i | input | THR_W (4) | Load threshold, in occupancy units per cycle |
| link_done_i | input | NLINK (24) | Per-link pulse confirming the switch to FIFO mode |
| lvl_done_i | input | NREG (16) | Per-region pulse confirming a stable new supply and clock |
| link_mode_o | output | NLINK (24) | Per-link mode: 1 is FIFO, 0 is wire |
| lvl_req_o | output | NREG (16) | Per-region requested level: 1 is high, 0 is low |

## Verification
The key collision is a window ending on the same cycle that the supply phase finishes, or on the cycle just after the controller returns to idle. The first case must store the result for later. The second must let the fresh result displace any stored one.

The bench sweeps the link and region acknowledge delays across a run of windows with alternating load patterns, so that sequence completion lands at many offsets from the window boundary. Some sequences are stretched past two windows so that a stored decision gets overwritten. A behavioural reference model predicts the level requests and link modes on every cycle, and any divergence is reported against the requirement under test.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LINKS  = 2'd1,
    PH_SUPPLY = 2'd2
  } phase_e;

endpackage

// File: rtl/region_load_avg.sv
module region_load_avg #(
  parameter int NREG   = 16,
  parameter int OCC_W  = 4,
  parameter int THR_W  = 4,
  parameter int WINDOW = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG*OCC_W-1:0] occ_i,
  input  logic [THR_W-1:0]      thresh_i,
  output logic                  win_end_o,
  output logic [NREG-1:0]       hot_o
);

  localparam int CNT_W = $clog2(WINDOW);
  localparam int ACC_W = OCC_W + CNT_W;
  localparam int CMP_W = ACC_W + THR_W;

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] limit;

  assign win_end_o = (cnt == CNT_W'(WINDOW - 1));
  assign limit     = CMP_W'(thresh_i) * CMP_W'(WINDOW);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (win_end_o) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    assign sum      = acc + ACC_W'(occ_i[g*OCC_W +: OCC_W]);
    assign hot_o[g] = CMP_W'(sum) > limit;

    always_ff @(posedge clk) begin
      if (!rst_n)         acc <= '0;
      else if (win_end_o) acc <= '0;
      else                acc <= sum;
    end
  end

  // Window wraps to zero right after its last cycle (R1)
  assert_window_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |=> (cnt == '0));

  // Counter never leaves its range (R1)
  assert_window_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(WINDOW));

endmodule

// File: rtl/link_boundary_map.sv
module link_boundary_map #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NREG  = ROWS * COLS,
  localparam int NH    = ROWS * (COLS - 1),
  localparam int NLINK = NH + (ROWS - 1) * COLS
) (
  input  logic [NREG-1:0]  lvl_i,
  output logic [NLINK-1:0] bnd_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_hrow
    for (genvar c = 0; c < COLS - 1; c++) begin : g_hcol
      assign bnd_o[r*(COLS-1)+c] = lvl_i[r*COLS+c] ^ lvl_i[r*COLS+c+1];
    end
  end

  for (genvar r = 0; r < ROWS - 1; r++) begin : g_vrow
    for (genvar c = 0; c < COLS; c++) begin : g_vcol
      assign bnd_o[NH+r*COLS+c] = lvl_i[r*COLS+c] ^ lvl_i[(r+1)*COLS+c];
    end
  end

endmodule

// File: rtl/reconfig_seq.sv
module reconfig_seq
  import dvfs_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int NLINK = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end_i,
  input  logic [NREG-1:0]  hot_i,
  input  logic [NLINK-1:0] link_done_i,
  input  logic [NREG-1:0]  lvl_done_i,
  input  logic [NLINK-1:0] cand_bnd_i,
  input  logic [NLINK-1:0] tgt_bnd_i,
  output logic [NREG-1:0]  cand_o,
  output logic [NREG-1:0]  tgt_o,
  output logic [NREG-1:0]  lvl_req_o,
  output logic [NLINK-1:0] link_mode_o
);

  phase_e           ph;
  logic             pend_v;
  logic [NREG-1:0]  pend;
  logic [NLINK-1:0] lpend;
  logic [NREG-1:0]  rpend;

  logic [NLINK-1:0] lpend_left;
  logic [NREG-1:0]  rpend_left;
  logic             take;
  logic             go;

  assign lpend_left = lpend & ~link_done_i;
  assign rpend_left = rpend & ~lvl_done_i;
  assign cand_o     = win_end_i ? hot_i : pend;
  assign take       = (ph == PH_IDLE) && (win_end_i || pend_v);
  assign go         = take && (cand_o != lvl_req_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      pend_v      <= 1'b0;
      pend        <= '0;
      tgt_o       <= '0;
      lpend       <= '0;
      rpend       <= '0;
      lvl_req_o   <= '0;
      link_mode_o <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (take) pend_v <= 1'b0;
          if (go) begin
            tgt_o       <= cand_o;
            lpend       <= cand_bnd_i & ~link_mode_o;
            link_mode_o <= link_mode_o | cand_bnd_i;
            ph          <= PH_LINKS;
          end
        end
        PH_LINKS: begin
          if (win_end_i) begin
            pend   <= hot_i;
            pend_v <= 1'b1;
          end
          lpend <= lpend_left;
          if (lpend_left == '0) begin
            lvl_req_o <= tgt_o;
            rpend     <= tgt_o ^ lvl_req_o;
            ph        <= PH_SUPPLY;
          end
        end
        PH_SUPPLY: begin
          if (win_end_i) begin
            pend   <= hot_i;
            pend_v <= 1'b1;
          end
          rpend <= rpend_left;
          if (rpend_left == '0) begin
            link_mode_o <= tgt_bnd_i;
            ph          <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Level requests move only when the interface phase completes (R3)
  assert_req_after_links_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_req_o) |-> ($past(ph) == PH_LINKS) && ($past(lpend_left) == '0));

  // Every boundary of the applied levels is in FIFO mode during the supply phase (R4)
  assert_supply_boundaries_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SUPPLY) |-> ((tgt_bnd_i & ~link_mode_o) == '0));

  // Outstanding link acknowledges refer only to links held in FIFO mode (R5)
  assert_pending_links_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LINKS) |-> ((lpend & ~link_mode_o) == '0));

  // A link drops back to wire mode only when the supply phase completes (R6)
  assert_wire_after_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(link_mode_o) & ~link_mode_o) != '0) |->
      ($past(ph) == PH_SUPPLY) && ($past(rpend_left) == '0));

  // An unchanged decision starts nothing (R8)
  assert_no_change_no_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cand_o == lvl_req_o)) |=> (ph == PH_IDLE) && $stable(link_mode_o));

endmodule

// File: rtl/dvfs_cluster_ctrl.sv
module dvfs_cluster_ctrl #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int OCC_W  = 4,
  parameter int THR_W  = 4,
  parameter int WINDOW = 50,
  localparam int NREG  = ROWS * COLS,
  localparam int NLINK = ROWS * (COLS - 1) + (ROWS - 1) * COLS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG*OCC_W-1:0] occ_i,
  input  logic [THR_W-1:0]      thresh_i,
  input  logic [NLINK-1:0]      link_done_i,
  input  logic [NREG-1:0]       lvl_done_i,
  output logic [NLINK-1:0]      link_mode_o,
  output logic [NREG-1:0]       lvl_req_o
);

  logic             win_end;
  logic [NREG-1:0]  hot;
  logic [NREG-1:0]  cand;
  logic [NREG-1:0]  tgt;
  logic [NLINK-1:0] cand_bnd;
  logic [NLINK-1:0] tgt_bnd;

  region_load_avg #(
    .NREG(NREG), .OCC_W(OCC_W), .THR_W(THR_W), .WINDOW(WINDOW)
  ) u_load (
    .clk(clk), .rst_n(rst_n), .occ_i(occ_i), .thresh_i(thresh_i),
    .win_end_o(win_end), .hot_o(hot)
  );

  link_boundary_map #(.ROWS(ROWS), .COLS(COLS)) u_cand_map (
    .lvl_i(cand), .bnd_o(cand_bnd)
  );

  link_boundary_map #(.ROWS(ROWS), .COLS(COLS)) u_tgt_map (
    .lvl_i(tgt), .bnd_o(tgt_bnd)
  );

  reconfig_seq #(.NREG(NREG), .NLINK(NLINK)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_end_i(win_end), .hot_i(hot),
    .link_done_i(link_done_i), .lvl_done_i(lvl_done_i),
    .cand_bnd_i(cand_bnd), .tgt_bnd_i(tgt_bnd),
    .cand_o(cand), .tgt_o(tgt), .lvl_req_o(lvl_req_o), .link_mode_o(link_mode_o)
  );

  // After reset, all regions request low and all links are wire (R9)
  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_n |=> (lvl_req_o == '0) && (link_mode_o == '0));

endmodule

// File: tb/tb_dvfs_cluster_ctrl.sv
`timescale 1ns/1ps
module tb_dvfs_cluster_ctrl;

  localparam int ROWS = 4, COLS = 4, OCC_W = 4, THR_W = 4, W = 50;
  localparam int NREG = ROWS * COLS;
  localparam int NH = ROWS * (COLS - 1);
  localparam int NLINK = NH + (ROWS - 1) * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREG*OCC_W-1:0] occ_i = '0;
  logic [THR_W-1:0] thresh_i = 4'd8;
  logic [NLINK-1:0] link_done_i = '0;
  logic [NREG-1:0] lvl_done_i = '0;
  logic [NLINK-1:0] link_mode_o;
  logic [NREG-1:0] lvl_req_o;

  always #2 clk = ~clk;

  dvfs_cluster_ctrl #(.ROWS(ROWS), .COLS(COLS), .OCC_W(OCC_W), .THR_W(THR_W), .WINDOW(W)) dut (
    .clk(clk), .rst_n(rst_n), .occ_i(occ_i), .thresh_i(thresh_i),
    .link_done_i(link_done_i), .lvl_done_i(lvl_done_i),
    .link_mode_o(link_mode_o), .lvl_req_o(lvl_req_o)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R9";
  int dl1 = 2, dl2 = 4, dr = 3;

  function automatic logic [NLINK-1:0] bmap(input logic [NREG-1:0] l);
    logic [NLINK-1:0] b = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (c < COLS - 1) b[r*(COLS-1)+c] = l[r*COLS+c] != l[r*COLS+c+1];
        if (r < ROWS - 1) b[NH+r*COLS+c] = l[r*COLS+c] != l[(r+1)*COLS+c];
      end
    return b;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_age, m_phase;
  int m_acc[NREG];
  logic [NREG-1:0] m_lvl, m_tgt, m_rpend, m_pend;
  logic [NLINK-1:0] m_mode, m_lpend;
  logic m_pv;

  always @(posedge clk) begin : model
    logic [NREG-1:0] hot, cand;
    logic win;
    int s;
    if (!rst_n) begin
      m_cnt = 0; m_age = 0; m_phase = 0; m_lvl = '0; m_tgt = '0; m_rpend = '0;
      m_pend = '0; m_mode = '0; m_lpend = '0; m_pv = 1'b0;
      for (int i = 0; i < NREG; i++) m_acc[i] = 0;
    end else begin
      win = (m_cnt == W - 1);
      for (int i = 0; i < NREG; i++) begin
        s = m_acc[i] + int'(occ_i[i*OCC_W +: OCC_W]);
        hot[i] = s > int'(thresh_i) * W;
        m_acc[i] = win ? 0 : s;
      end
      m_cnt = win ? 0 : m_cnt + 1;
      m_age++;
      if (m_phase == 0) begin
        if (win || m_pv) begin
          cand = win ? hot : m_pend;
          m_pv = 1'b0;
          if (cand != m_lvl) begin
            m_tgt = cand;
            m_lpend = bmap(cand) & ~m_mode;
            m_mode = m_mode | bmap(cand);
            m_phase = 1; m_age = 0;
          end
        end
      end else if (m_phase == 1) begin
        if (win) begin m_pend = hot; m_pv = 1'b1; end
        m_lpend = m_lpend & ~link_done_i;
        if (m_lpend == '0) begin
          m_rpend = m_tgt ^ m_lvl; m_lvl = m_tgt; m_phase = 2; m_age = 0;
        end
      end else begin
        if (win) begin m_pend = hot; m_pv = 1'b1; end
        m_rpend = m_rpend & ~lvl_done_i;
        if (m_rpend == '0) begin
          m_mode = bmap(m_tgt); m_phase = 0;
        end
      end
    end
  end

  // Per-cycle comparison, then acknowledge responders (links and regions)
  always @(negedge clk) begin
    chk(cur_req, "lvl_req_o", 32'(lvl_req_o), rst_n ? 32'(m_lvl) : 32'h0);
    chk(cur_req, "link_mode_o", 32'(link_mode_o), rst_n ? 32'(m_mode) : 32'h0);
    link_done_i = '0;
    lvl_done_i = '0;
    if (rst_n && m_phase == 1)
      for (int k = 0; k < NLINK; k++)
        if (m_lpend[k] && (((k % 2) == 0 && m_age == dl1) || ((k % 2) == 1 && m_age == dl2)))
          link_done_i[k] = 1'b1;
    if (rst_n && m_phase == 2) begin
      if (m_age == 0) lvl_done_i = ~m_rpend;   // stray pulses must be ignored (R6)
      if (m_age == dr) lvl_done_i = m_rpend;
    end
  end

  task automatic wait_win();
    do @(negedge clk); while (m_cnt != 0);
    #1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_phase != 0 || m_pv);
    #1;
  endtask

  task automatic set_pat(input logic [NREG-1:0] hi, input int vhi, input int vlo);
    for (int i = 0; i < NREG; i++) occ_i[i*OCC_W +: OCC_W] = OCC_W'(hi[i] ? vhi : vlo);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset lvl", 32'(lvl_req_o), 32'h0);
    chk("R9", "reset mode", 32'(link_mode_o), 32'h0);
    #1 rst_n = 1'b1;

    // R8: low load, no change over a whole window
    cur_req = "R8";
    set_pat('0, 0, 2);
    wait_win(); wait_win(); repeat (3) @(negedge clk);
    chk("R8", "lvl unchanged", 32'(lvl_req_o), 32'h0);
    chk("R8", "mode unchanged", 32'(link_mode_o), 32'h0);

    // R2/R4/R5/R6: corner cluster, region 5 sits exactly on the limit
    #1 cur_req = "R2";
    wait_win();
    set_pat(16'h0013, 9, 3);
    occ_i[5*OCC_W +: OCC_W] = 4'd8;
    dl1 = 3; dl2 = 6; dr = 4;
    wait_win(); wait_idle();
    chk("R2", "hot cluster levels", 32'(lvl_req_o), 32'h0013);
    chk("R4", "boundary modes", 32'(link_mode_o), 32'(bmap(16'h0013)));

    // R1: one extra unit in the last window cycle lifts region 10 over the limit
    cur_req = "R1";
    wait_win();
    occ_i[10*OCC_W +: OCC_W] = 4'd8;
    do @(negedge clk); while (m_cnt != W - 1);
    #1 occ_i[10*OCC_W +: OCC_W] = 4'd9;
    @(negedge clk); #1 occ_i[10*OCC_W +: OCC_W] = 4'd8;
    wait_idle();
    chk("R1", "last-cycle sample counted", 32'(lvl_req_o[10]), 32'h1);

    // R5: all regions go high, so no link changes mode
    cur_req = "R5";
    wait_win();
    thresh_i = 4'd2; set_pat('1, 3, 3);
    wait_win(); wait_idle();
    chk("R5", "all high", 32'(lvl_req_o), 32'hFFFF);
    chk("R5", "no boundaries", 32'(link_mode_o), 32'h0);

    // R3/R6/R7: sweep acknowledge delays so completions land near window ends
    thresh_i = 4'd8;
    for (int k = 0; k < 16; k++) begin
      wait_win();
      cur_req = (k % 3 == 0) ? "R3" : ((k % 3 == 1) ? "R6" : "R7");
      dl1 = k; dl2 = k + 5; dr = (k >= 13) ? 120 : 30 + k;
      set_pat((16'h1357 << (k % 5)) ^ NREG'(k * 16'h0911), 9, 3);
    end
    cur_req = "R7";
    wait_idle(); wait_win(); wait_idle();
    chk("R7", "final levels settle", 32'(lvl_req_o), 32'(m_lvl));
    chk("R4", "final idle map", 32'(link_mode_o), 32'(bmap(lvl_req_o)));
    summary();
  end

endmodule